// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART's serial receiver and the host register interface. The receiver offers one character word at a time, made of eight data bits and four status bits above them. A separate strobe reports a line break. The buffer keeps the words in a circular store of sixteen entries, tracked by a read position and an occupancy count. It hands the oldest word to the host on a read strobe. On every host read it moves that word's status bits into a status register.

A mode input selects the buffering. In buffered mode all sixteen entries are used. In holding mode the block acts as a single holding register. Any change of the mode input empties the buffer. The block drives empty and full flags, a ready signal back to the receiver, a one-cycle overrun pulse when an offered word is dropped, and a receive-interrupt level. The interrupt level is set when a push makes the count equal to a trigger level, and it is cleared when a pop brings the count down to one below that level.

Top module: `uart_rx_buffer`

## Requirements
- R1: After synchronous active-high reset the block is empty: `empty`=1, `full`=0, `rx_irq`=0 and `rx_ready`=1.
- R2: With `fifo_en`=1 the block accepts up to 16 words and returns them in arrival order. `full` rises and `rx_ready` falls when the count reaches 16.
- R3: With `fifo_en`=0 the block accepts a word only when the count is zero. `full` is set once one word is held.
- R4: In the cycle where `fifo_en` differs from its value in the previous cycle, the buffer is flushed. The count and the read position return to zero, `empty` becomes 1 and `rx_irq` becomes 0. A push or read offered in that cycle is ignored.
- R5: `empty` is 1 exactly when the count is zero. `full` is 1 exactly when the count equals the capacity of the current mode. A read clears `full`.
- R6: A read while the buffer is empty leaves the count and the read position unchanged.
- R7: Each read registers bits [11:8] of the head word into `rd_status`, one cycle after the read strobe. `rd_data` always shows bits [7:0] of the head word.
- R8: A `rx_break` strobe pushes a word with data 0x00 and only status bit 2 (word bit 10) set. `rx_break` takes priority over `rx_valid` in the same cycle.
- R9: `rx_irq` is set when an accepted push makes the count equal to `trig_level`.
- R10: `rx_irq` is cleared when a read makes the count equal to `trig_level` minus one.
- R11: A push and a read in the same cycle are both applied. The count stays the same and the word order is kept.
- R12: A word offered while the buffer is at capacity is dropped, and `overrun` pulses for one cycle after that clock edge.
- R13: The read and write positions wrap modulo 16, so word order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: sixteen-entry buffering; 0: single holding register |
| trig_level | input | 5 | Interrupt trigger count, 1 to 16 |
| rx_valid | input | 1 | Receiver offers `rx_word` this cycle |
| rx_word | input | 12 | Received word: [7:0] data, [11:8] status |
| rx_break | input | 1 | Line break seen; pushes the break word |
| rx_ready | output | 1 | The buffer can take a word this cycle |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Data bits of the head word |
| rd_status | output | 4 | Status bits of the most recently read word |
| empty | output | 1 | Buffer holds no word |
| full | output | 1 | Buffer is at the capacity of its mode |
| rx_irq | output | 1 | Receive interrupt level |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
A receiver push and a host read can land in the same clock edge. The bench provokes this in buffered mode with the buffer partly filled and the trigger level set to that count. This tests both the count-preserving path and the rule that decides the interrupt when both events occur together. The scoreboard judges the result in three ways: the head word read in that cycle must be the oldest queued word, the newly pushed word must come out last, and the flags and interrupt must match a count that did not change.

// File: rtl/uart_rxbuf_pkg.sv
`timescale 1ns/1ps
package uart_rxbuf_pkg;
   // Position of each status bit inside the status field (above the data bits)
   typedef enum int unsigned {
      ST_FRAME   = 0,
      ST_PARITY  = 1,
      ST_BREAK   = 2,
      ST_OVERRUN = 3
   } rxb_status_bit_e;

   localparam int unsigned RXB_MIN_STAT_W = 4;
endpackage

// File: rtl/rxbuf_ptr_ctrl.sv
`timescale 1ns/1ps
module rxbuf_ptr_ctrl #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fifo_en,
   input  logic             push_req,
   input  logic             rd_en,
   output logic [PTR_W-1:0] rd_pos,
   output logic [PTR_W-1:0] wr_slot,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] cap,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             flush,
   output logic             can_accept,
   output logic             overrun
);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic             mode_q;
   logic [PTR_W-1:0] pos_inc;
   logic [PTR_W:0]   slot_sum;

   assign flush      = (fifo_en != mode_q);
   assign cap        = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
   assign can_accept = !flush && (cnt < cap);
   assign push_ok    = push_req && can_accept;
   assign pop_ok     = rd_en && !flush && (cnt != '0);
   assign cnt_nxt    = flush ? '0 : (cnt + CNT_W'(push_ok) - CNT_W'(pop_ok));
   assign slot_sum   = {1'b0, rd_pos} + (PTR_W+1)'(cnt);

   generate
      if (POW2) begin : g_wrap_mask
         assign pos_inc = rd_pos + 1'b1;
         assign wr_slot = slot_sum[PTR_W-1:0];
      end else begin : g_wrap_cmp
         assign pos_inc = (rd_pos == PTR_W'(DEPTH-1)) ? '0 : rd_pos + 1'b1;
         assign wr_slot = (slot_sum >= (PTR_W+1)'(DEPTH)) ?
                          PTR_W'(slot_sum - (PTR_W+1)'(DEPTH)) : slot_sum[PTR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= 1'b0;
         cnt     <= '0;
         rd_pos  <= '0;
         overrun <= 1'b0;
      end else begin
         mode_q  <= fifo_en;
         overrun <= push_req && !flush && (cnt >= cap);
         cnt     <= cnt_nxt;
         if (flush)       rd_pos <= '0;
         else if (pop_ok) rd_pos <= pos_inc;
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt <= cap)
      else $error("count above mode capacity");
   p_single_cap_r3: assert property (@(posedge clk) disable iff (rst)
      (!mode_q) |-> (cnt <= CNT_W'(1)))
      else $error("holding mode holds more than one word");
   p_flush_r4: assert property (@(posedge clk) disable iff (rst)
      flush |=> (cnt == '0 && rd_pos == '0))
      else $error("mode change did not flush");
   p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && cnt == '0 && !flush) |=> (rd_pos == $past(rd_pos)))
      else $error("empty read moved the read position");
   p_push_pop_r11: assert property (@(posedge clk) disable iff (rst)
      (push_ok && pop_ok) |=> (cnt == $past(cnt)))
      else $error("simultaneous push and pop changed count");
   p_drop_r12: assert property (@(posedge clk) disable iff (rst)
      (push_req && !flush && cnt == cap) |=> overrun)
      else $error("dropped push without overrun pulse");
endmodule

// File: rtl/rxbuf_store.sv
`timescale 1ns/1ps
module rxbuf_store #(
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 4,
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   // Datapath storage, not reset: the occupancy count alone says what is valid
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/rxbuf_status.sv
`timescale 1ns/1ps
module rxbuf_status #(
   parameter int DATA_W = 8,
   parameter int STAT_W = 4,
   parameter int CNT_W  = 5,
   localparam int WORD_W = DATA_W + STAT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  cnt_nxt,
   input  logic [CNT_W-1:0]  cap,
   input  logic [CNT_W-1:0]  trig,
   input  logic              push_ok,
   input  logic              pop_ok,
   input  logic              flush,
   input  logic              rd_en,
   input  logic [WORD_W-1:0] head_word,
   output logic              empty_q,
   output logic              full_q,
   output logic              irq_q,
   output logic [STAT_W-1:0] status_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         empty_q  <= 1'b1;
         full_q   <= 1'b0;
         irq_q    <= 1'b0;
         status_q <= '0;
      end else begin
         empty_q <= (cnt_nxt == '0);
         full_q  <= !flush && (cnt_nxt == cap);
         if (flush)                                     irq_q <= 1'b0;
         else if (push_ok && cnt_nxt == trig)           irq_q <= 1'b1;
         else if (pop_ok && cnt_nxt == trig - 1'b1)     irq_q <= 1'b0;
         if (rd_en) status_q <= head_word[WORD_W-1:DATA_W];
      end
   end

   p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst) !(empty_q && full_q))
      else $error("empty and full together");
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_q) |-> $past(push_ok))
      else $error("interrupt rose without a push");
   p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_q) |-> ($past(pop_ok) || $past(flush)))
      else $error("interrupt fell without a pop or flush");
   p_trig_range_r9: assert property (@(posedge clk) disable iff (rst) trig != '0)
      else $error("trigger level of zero");
endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
module uart_rx_buffer #(
   parameter int DATA_W = 8,
   parameter int STAT_W = 4,
   parameter int DEPTH  = 16,
   localparam int WORD_W = DATA_W + STAT_W,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fifo_en,
   input  logic [CNT_W-1:0]  trig_level,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_break,
   output logic              rx_ready,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [STAT_W-1:0] rd_status,
   output logic              empty,
   output logic              full,
   output logic              rx_irq,
   output logic              overrun
);
   import uart_rxbuf_pkg::*;

   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << (DATA_W + int'(ST_BREAK));

   generate
      if (DEPTH < 2)                  begin : g_chk_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1)                 begin : g_chk_data  $error("DATA_W must be positive"); end
      if (STAT_W < RXB_MIN_STAT_W)    begin : g_chk_stat  $error("STAT_W too small for break bit"); end
   endgenerate

   logic              push_req;
   logic [WORD_W-1:0] push_word;
   logic [PTR_W-1:0]  rd_pos, wr_slot;
   logic [CNT_W-1:0]  cnt, cnt_nxt, cap;
   logic              push_ok, pop_ok, flush;
   logic [WORD_W-1:0] head_word;

   assign push_req  = rx_valid || rx_break;
   assign push_word = rx_break ? BRK_WORD : rx_word;

   rxbuf_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst(rst), .fifo_en(fifo_en), .push_req(push_req), .rd_en(rd_en),
      .rd_pos(rd_pos), .wr_slot(wr_slot), .cnt(cnt), .cnt_nxt(cnt_nxt), .cap(cap),
      .push_ok(push_ok), .pop_ok(pop_ok), .flush(flush), .can_accept(rx_ready),
      .overrun(overrun)
   );

   rxbuf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .WORD_W(WORD_W)) u_store (
      .clk(clk), .wr_en(push_ok), .wr_addr(wr_slot), .wr_data(push_word),
      .rd_addr(rd_pos), .rd_word(head_word)
   );

   rxbuf_status #(.DATA_W(DATA_W), .STAT_W(STAT_W), .CNT_W(CNT_W)) u_stat (
      .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .cap(cap), .trig(trig_level),
      .push_ok(push_ok), .pop_ok(pop_ok), .flush(flush), .rd_en(rd_en),
      .head_word(head_word), .empty_q(empty), .full_q(full), .irq_q(rx_irq),
      .status_q(rd_status)
   );

   assign rd_data = head_word[DATA_W-1:0];

   p_break_push_r8: assert property (@(posedge clk) disable iff (rst)
      (rx_break && rx_ready) |=> !empty)
      else $error("accepted break left buffer empty");
   p_ready_full_r2: assert property (@(posedge clk) disable iff (rst)
      (full && !rd_en && !rx_valid && !rx_break && $stable(fifo_en)) |=> full)
      else $error("full flag dropped without a read");
endmodule

// File: tb/uart_rx_buffer_bench.sv
`timescale 1ns/1ps
module uart_rx_buffer_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fifo_en = 1'b0;
   logic [4:0]  trig_level = 5'd1;
   logic        rx_valid = 1'b0;
   logic [11:0] rx_word = '0;
   logic        rx_break = 1'b0;
   logic        rd_en = 1'b0;
   logic        rx_ready, empty, full, rx_irq, overrun;
   logic [7:0]  rd_data;
   logic [3:0]  rd_status;

   int checks = 0;
   int errors = 0;
   logic [11:0] exp_q[$];
   int  cap_m = 1;
   bit  irq_m = 1'b0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   uart_rx_buffer u_uart_rx_buffer (
      .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_level(trig_level),
      .rx_valid(rx_valid), .rx_word(rx_word), .rx_break(rx_break), .rx_ready(rx_ready),
      .rd_en(rd_en), .rd_data(rd_data), .rd_status(rd_status), .empty(empty),
      .full(full), .rx_irq(rx_irq), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_flags(input string tag);
      chk(empty == (exp_q.size() == 0), {tag, " empty"}, empty, exp_q.size() == 0);
      chk(full == (exp_q.size() == cap_m), {tag, " full"}, full, exp_q.size() == cap_m);
      chk(rx_irq == irq_m, {tag, " irq"}, rx_irq, irq_m);
   endtask

   // driver: offers a word (or break) and records what must come out
   task automatic push(input logic [11:0] w, input bit brk, input string tag);
      bit acc;
      acc = (exp_q.size() < cap_m);
      chk(rx_ready == acc, {tag, " ready"}, rx_ready, acc);
      rx_valid = !brk; rx_break = brk; rx_word = w;
      tick();
      rx_valid = 1'b0; rx_break = 1'b0;
      if (acc) begin
         exp_q.push_back(brk ? 12'h400 : w);
         if (exp_q.size() == int'(trig_level)) irq_m = 1'b1;
         chk(overrun == 1'b0, {tag, " no overrun"}, overrun, 0);
      end else begin
         chk(overrun == 1'b1, "R12 overrun pulse", overrun, 1);
      end
      chk_flags(tag);
   endtask

   // monitor side of a read: compare head word with scoreboard
   task automatic pop(input string tag);
      logic [11:0] e;
      if (exp_q.size() > 0) begin
         e = exp_q[0];
         chk(rd_data == e[7:0], {tag, " data"}, rd_data, e[7:0]);
      end
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      if (exp_q.size() > 0) begin
         chk(rd_status == e[11:8], "R7 status", rd_status, e[11:8]);
         void'(exp_q.pop_front());
         if (exp_q.size() == int'(trig_level) - 1) irq_m = 1'b0;
      end
      chk_flags(tag);
   endtask

   task automatic pop_push(input logic [11:0] w, input string tag);
      logic [11:0] e;
      bit acc;
      int nsz;
      acc = (exp_q.size() < cap_m);
      e = exp_q[0];
      chk(rd_data == e[7:0], {tag, " head"}, rd_data, e[7:0]);
      rd_en = 1'b1; rx_valid = 1'b1; rx_word = w;
      tick();
      rd_en = 1'b0; rx_valid = 1'b0;
      void'(exp_q.pop_front());
      if (acc) exp_q.push_back(w);
      nsz = exp_q.size();
      if (acc && nsz == int'(trig_level)) irq_m = 1'b1;
      else if (nsz == int'(trig_level) - 1) irq_m = 1'b0;
      chk_flags(tag);
   endtask

   task automatic set_mode(input bit m);
      fifo_en = m;
      tick();
      exp_q.delete();
      irq_m = 1'b0;
      cap_m = m ? 16 : 1;
      chk(empty == 1'b1, "R4 flush empty", empty, 1);
      chk(rx_irq == 1'b0, "R4 flush irq", rx_irq, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst = 1'b0;
      tick();
      // R1 reset state
      chk(empty == 1'b1, "R1 empty", empty, 1);
      chk(full == 1'b0, "R1 full", full, 0);
      chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
      chk(rx_ready == 1'b1, "R1 ready", rx_ready, 1);

      // R3 holding mode: one word, second dropped (R12)
      push(12'h1A5, 1'b0, "R3 first");
      chk(rx_ready == 1'b0, "R3 ready low", rx_ready, 0);
      push(12'h0C3, 1'b0, "R3 second dropped");
      pop("R10 holding read");
      // R8 break word
      push(12'h0FF, 1'b1, "R8 break");
      chk(rd_data == 8'h00, "R8 break data", rd_data, 0);
      pop("R8 break read");
      // R6 empty read leaves state untouched
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      chk(empty == 1'b1, "R6 still empty", empty, 1);

      // R2 / R13 buffered mode with wrap
      set_mode(1'b1);
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      chk(empty == 1'b1, "R6 empty read buffered", empty, 1);
      for (int i = 0; i < 3; i++) push(12'(12'h210 + i), 1'b0, "R2 pre");
      for (int i = 0; i < 3; i++) pop("R2 pre read");
      for (int i = 0; i < 16; i++) push(12'((i * 37 + 5) & 12'hFFF), 1'b0, "R13 fill");
      chk(full == 1'b1, "R2 full at 16", full, 1);
      chk(rx_ready == 1'b0, "R2 ready low", rx_ready, 0);
      push(12'h777, 1'b0, "R12 drop in buffered");
      pop("R5 read clears full");
      chk(full == 1'b0, "R5 full cleared", full, 0);
      while (exp_q.size() > 0) pop("R13 drain");

      // R9 / R10 trigger level 4, R11 simultaneous push and read
      trig_level = 5'd4;
      for (int i = 0; i < 3; i++) push(12'(12'h340 + i), 1'b0, "R9 below trigger");
      chk(rx_irq == 1'b0, "R9 not yet", rx_irq, 0);
      push(12'h9AB, 1'b0, "R9 reach trigger");
      chk(rx_irq == 1'b1, "R9 raised", rx_irq, 1);
      pop("R10 drop below trigger");
      chk(rx_irq == 1'b0, "R10 cleared", rx_irq, 0);
      pop_push(12'h5E1, "R11 both");
      pop_push(12'hA0F, "R11 both again");
      push(12'h111, 1'b0, "R9 reach again");
      pop_push(12'h222, "R11 at trigger");
      while (exp_q.size() > 0) pop("R11 drain");

      // R4 flush with content, then holding mode use
      trig_level = 5'd1;
      push(12'h0AA, 1'b0, "R4 pre");
      push(12'h0BB, 1'b0, "R4 pre");
      set_mode(1'b0);
      push(12'h3CC, 1'b0, "R4 after flush");
      pop("R4 after flush read");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule